// File: doc/BRIEF.md
# Deferred Status Flag Evaluator

This block turns a recorded description of the last flag-setting instruction into updated processor status flags. A pipeline that skips flag computation on the fast path saves the operation class, the operand size, both operands, the result and the upper product word. When the flags are needed later, it presents them here together with the current status byte and the instruction's flag write mask. The evaluator derives the negative, zero, overflow, carry and multiply-accumulate carry flags and merges them into the status byte. The ALU that produced the result is not part of this block.

Each evaluation is started by a one-cycle strobe. The merged status appears on a registered output one clock later, with a matching valid pulse. Addition, subtraction and compare rules work at byte, halfword or word width. The multiply rules look at a 64-bit product. Logic, move and shift classes report only sign and zero. One class passes the status through unchanged because its flags are already current.

Status byte layout: bit 0 C (carry), bit 1 V (overflow), bit 2 Z (zero), bit 3 N (negative), bit 4 X (extended arithmetic), bit 5 R (multiply-accumulate carry), bits 7:6 other state. Operation codes: 0 add, 1 add-with-carry, 2 sub, 3 cmp, 4 move, 5 and, 6 or, 7 xor, 8 arithmetic right shift, 9 logical right shift, 10 left shift, 11 signed multiply, 12 unsigned multiply, 13 multiply-accumulate class, 14 flags-live, 15 treated as add. Size codes: 0 byte, 1 halfword, 2 word, 3 no valid size.

Top module: `lcc_eval`

## Requirements
- R1: While reset is asserted and after its release, `ccs_q` is 8'h00 and `out_vld` is 0 until the first evaluation.
- R2: An evaluation strobed on `eval_vld` updates `ccs_q` at the next rising clock edge and raises `out_vld` for exactly that cycle. Without a strobe, `ccs_q` holds its value and `out_vld` is 0.
- R3: Add-rule classes (codes 0 to 3 and 15), when the result sign bit is 1: N=1, Z=0, V=1 if both operand sign bits are 0, and C=1 if both are 1.
- R4: Add-rule classes, when the result sign bit is 0: N=0, Z=1 if the sized result is zero, V=1 if both operand sign bits are 1, and C=1 if either operand sign bit is 1.
- R5: For sub (2) and cmp (3), the source sign used by R3 and R4 is inverted, and the final C is inverted.
- R6: The sign bit is bit 7, 15 or 31 for size codes 0, 1 and 2, and Z examines only the low 8, 16 or 32 result bits. With size code 3, add-rule classes produce no flags, except that sub and cmp produce C=1.
- R7: Move, logic and shift classes (codes 4 to 10) produce N from the sized sign bit and Z from the sized zero test. Their V, C and R are 0.
- R8: Signed multiply (11) forms {mul_hi, result}. Z=1 if that value is zero; otherwise N is its bit 63. V=1 unless mul_hi equals the sign extension of result. C and R are 0.
- R9: Unsigned multiply (12) forms the same 64-bit value. Z=1 if it is zero, N is bit 63, V=1 when mul_hi is nonzero, and C and R are 0.
- R10: The multiply-accumulate class (13) uses the word-size add rule without inversion. It writes the carry-like outcome into R (bit 5) and gives C=0.
- R11: When the incoming X bit is 1, or the class is add-with-carry, the Z bit is dropped from the write mask and the old Z is kept.
- R12: Every evaluation other than flags-live clears X. Bits outside the write mask keep their old value, and bits inside it take the computed flag, which is 0 for bits that have no flag.
- R13: The flags-live class (14) returns the incoming status byte unchanged, including X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_vld | input | 1 | Evaluation strobe |
| op_code | input | 4 | Recorded operation class |
| size_code | input | 2 | Operand size code |
| src_opnd | input | 32 | Source operand |
| dst_opnd | input | 32 | Destination operand |
| result | input | 32 | Recorded result (low product word for multiplies) |
| mul_hi | input | 32 | High product word |
| wr_mask | input | 8 | Flag write mask |
| ccs_in | input | 8 | Current status byte |
| ccs_q | output | 8 | Merged status byte |
| out_vld | output | 1 | Result valid, one cycle after the strobe |

## Verification
The bench targets the following corner cases, and each catches a specific class of design error:

- Sums that wrap exactly to zero at word width, and halfword results whose zero test must ignore the upper bits. A design that took the sign or zero test from the wrong width would report Z or N wrongly here.
- Compares of equal operands and subtracts at the invalid size. A design that missed either inversion would report a borrow on equal operands, or no borrow at size code 3.
- Signed products whose high word is all ones with a negative low word, and unsigned products with only the high word set. These expose an overflow test that ignores the sign extension, or a sign test taken from the wrong word.
- Add-with-carry and X-set cases with the old Z set, partial masks that include non-flag bits, and flags-live passes. A design that lost the old Z, left X set, or touched unmasked bits fails these.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  localparam int SW       = 8;
  localparam int NSZ      = 3;
  localparam int B_C      = 0;
  localparam int B_V      = 1;
  localparam int B_Z      = 2;
  localparam int B_N      = 3;
  localparam int B_X      = 4;
  localparam int B_R      = 5;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_CMP  = 4'd3,
    OP_MOVE = 4'd4,  OP_AND  = 4'd5,  OP_OR   = 4'd6,  OP_XOR  = 4'd7,
    OP_ASR  = 4'd8,  OP_LSR  = 4'd9,  OP_LSL  = 4'd10, OP_MULS = 4'd11,
    OP_MULU = 4'd12, OP_MCP  = 4'd13, OP_LIVE = 4'd14, OP_RSVD = 4'd15
  } op_e;

  function automatic logic is_nz_class(op_e op);
    return (op >= OP_MOVE) && (op <= OP_LSL);
  endfunction

  function automatic logic is_inv_class(op_e op);
    return (op == OP_SUB) || (op == OP_CMP);
  endfunction
endpackage

// File: rtl/lcc_arith_flags.sv
module lcc_arith_flags #(
  parameter int DW  = 32,
  parameter int SZW = 2
) (
  input  logic [SZW-1:0] size_code,
  input  logic           inv_src,
  input  logic [DW-1:0]  src,
  input  logic [DW-1:0]  dst,
  input  logic [DW-1:0]  res,
  output logic           n_o,
  output logic           z_o,
  output logic           v_o,
  output logic           cy_o,
  output logic           size_ok
);
  localparam int NCODE = 1 << SZW;

  logic [NCODE-1:0] s_sg, d_sg, r_sg, r_zero;

  for (genvar g = 0; g < NCODE; g++) begin : g_sz
    if (g < lcc_pkg::NSZ) begin : g_valid
      localparam int W = 8 << g;
      assign s_sg[g]   = src[W-1] ^ inv_src;
      assign d_sg[g]   = dst[W-1];
      assign r_sg[g]   = res[W-1];
      assign r_zero[g] = (res[W-1:0] == '0);
    end else begin : g_none
      assign s_sg[g]   = 1'b0;
      assign d_sg[g]   = 1'b0;
      assign r_sg[g]   = 1'b0;
      assign r_zero[g] = 1'b0;
    end
  end

  logic s, d;
  assign size_ok = (int'(size_code) < lcc_pkg::NSZ);
  assign s       = s_sg[size_code];
  assign d       = d_sg[size_code];

  always_comb begin
    n_o  = 1'b0;
    z_o  = 1'b0;
    v_o  = 1'b0;
    cy_o = 1'b0;
    if (size_ok) begin
      if (r_sg[size_code]) begin
        n_o  = 1'b1;
        v_o  = !s && !d;
        cy_o = s && d;
      end else begin
        z_o  = r_zero[size_code];
        v_o  = s && d;
        cy_o = s || d;
      end
    end
  end
endmodule

// File: rtl/lcc_mul_flags.sv
module lcc_mul_flags #(
  parameter int DW = 32
) (
  input  logic          signed_mode,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic          n_o,
  output logic          z_o,
  output logic          v_o
);
  logic hi_is_ext;

  assign z_o       = ({hi, lo} == '0);
  assign n_o       = !z_o && hi[DW-1];
  assign hi_is_ext = (hi == {DW{lo[DW-1]}});
  assign v_o       = signed_mode ? !hi_is_ext : (hi != '0);
endmodule

// File: rtl/lcc_merge.sv
module lcc_merge #(
  parameter int SW = 8
) (
  input  logic [SW-1:0] old_ccs,
  input  logic [SW-1:0] flags,
  input  logic [SW-1:0] mask,
  input  logic          z_keep,
  output logic [SW-1:0] new_ccs
);
  logic [SW-1:0] eff_mask, clr_mask;

  always_comb begin
    eff_mask = mask;
    if (z_keep) eff_mask[lcc_pkg::B_Z] = 1'b0;
    clr_mask = eff_mask;
    clr_mask[lcc_pkg::B_X] = 1'b1;
    new_ccs  = (old_ccs & ~clr_mask) | (flags & eff_mask);
  end
endmodule

// File: rtl/lcc_eval.sv
module lcc_eval
  import lcc_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SZW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           eval_vld,
  input  logic [3:0]     op_code,
  input  logic [SZW-1:0] size_code,
  input  logic [DW-1:0]  src_opnd,
  input  logic [DW-1:0]  dst_opnd,
  input  logic [DW-1:0]  result,
  input  logic [DW-1:0]  mul_hi,
  input  logic [SW-1:0]  wr_mask,
  input  logic [SW-1:0]  ccs_in,
  output logic [SW-1:0]  ccs_q,
  output logic           out_vld
);
  localparam logic [SZW-1:0] WORD_SZ = SZW'(NSZ - 1);

  op_e op;
  assign op = op_e'(op_code);

  // general add-rule evaluation, sized
  logic ar_n, ar_z, ar_v, ar_cy, ar_ok;
  logic inv_sel;
  assign inv_sel = is_inv_class(op);

  lcc_arith_flags #(.DW(DW), .SZW(SZW)) u_arith (
    .size_code(size_code), .inv_src(inv_sel),
    .src(src_opnd), .dst(dst_opnd), .res(result),
    .n_o(ar_n), .z_o(ar_z), .v_o(ar_v), .cy_o(ar_cy), .size_ok(ar_ok)
  );

  // multiply-accumulate class: word size, no inversion
  logic mc_n, mc_z, mc_v, mc_cy, mc_ok;
  lcc_arith_flags #(.DW(DW), .SZW(SZW)) u_mcp (
    .size_code(WORD_SZ), .inv_src(1'b0),
    .src(src_opnd), .dst(dst_opnd), .res(result),
    .n_o(mc_n), .z_o(mc_z), .v_o(mc_v), .cy_o(mc_cy), .size_ok(mc_ok)
  );

  logic mu_n, mu_z, mu_v;
  lcc_mul_flags #(.DW(DW)) u_mul (
    .signed_mode(op == OP_MULS), .lo(result), .hi(mul_hi),
    .n_o(mu_n), .z_o(mu_z), .v_o(mu_v)
  );

  logic [SW-1:0] flg;
  always_comb begin
    flg = '0;
    if (op == OP_MULS || op == OP_MULU) begin
      flg[B_N] = mu_n;
      flg[B_Z] = mu_z;
      flg[B_V] = mu_v;
    end else if (op == OP_MCP) begin
      flg[B_N] = mc_n;
      flg[B_Z] = mc_z;
      flg[B_V] = mc_v;
      flg[B_R] = mc_cy;
    end else if (is_nz_class(op)) begin
      flg[B_N] = ar_n;
      flg[B_Z] = ar_z;
    end else begin
      flg[B_N] = ar_n;
      flg[B_Z] = ar_z;
      flg[B_V] = ar_v;
      flg[B_C] = ar_cy ^ inv_sel;
    end
  end

  logic          z_keep;
  logic [SW-1:0] merged;
  assign z_keep = ccs_in[B_X] || (op == OP_ADDC);

  lcc_merge #(.SW(SW)) u_merge (
    .old_ccs(ccs_in), .flags(flg), .mask(wr_mask),
    .z_keep(z_keep), .new_ccs(merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccs_q   <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= eval_vld;
      if (eval_vld) ccs_q <= (op == OP_LIVE) ? ccs_in : merged;
    end
  end

  AST_VLD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    eval_vld |=> out_vld); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_vld |=> (!out_vld && $stable(ccs_q))); // R2
  AST_ARITH_NZ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_vld && ar_n) |-> !ar_z); // R4
  AST_MULU_ZERO_NOV: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_vld && op == OP_MULU && mu_z) |-> !mu_v); // R9
  AST_Z_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_vld && op != OP_LIVE && z_keep) |=> (ccs_q[B_Z] == $past(ccs_in[B_Z]))); // R11
  AST_X_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_vld && op != OP_LIVE) |=> !ccs_q[B_X]); // R12
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_vld && op != OP_LIVE) |=>
      (((ccs_q ^ $past(ccs_in)) & ~$past(wr_mask) & ~(SW'(1) << B_X)) == '0)); // R12
  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_vld && op == OP_LIVE) |=> (ccs_q == $past(ccs_in))); // R13
endmodule

// File: tb/tb_lcc_eval.sv
module tb_lcc_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval_vld = 1'b0;
  logic [3:0]  op_code = '0;
  logic [1:0]  size_code = '0;
  logic [31:0] src_opnd = '0, dst_opnd = '0, result = '0, mul_hi = '0;
  logic [7:0]  wr_mask = '0, ccs_in = '0;
  logic [7:0]  ccs_q;
  logic        out_vld;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  lcc_eval dut (
    .clk(clk), .rst_n(rst_n), .eval_vld(eval_vld), .op_code(op_code),
    .size_code(size_code), .src_opnd(src_opnd), .dst_opnd(dst_opnd),
    .result(result), .mul_hi(mul_hi), .wr_mask(wr_mask), .ccs_in(ccs_in),
    .ccs_q(ccs_q), .out_vld(out_vld)
  );

  // expected flags, restated as carry/overflow majority functions
  function automatic logic [7:0] model(input logic [3:0] op, input logic [1:0] sz,
      input logic [31:0] s_in, d_in, r_in, h_in, input logic [7:0] m, old);
    logic [7:0] f = 8'h00;
    logic [7:0] em = m;
    logic [63:0] p = {h_in, r_in};
    int w;
    logic s, d, r, zero, inv;
    if (op == 4'd14) return old;
    w = (op == 4'd13) ? 32 : (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : (sz == 2'd2) ? 32 : 0;
    inv = (op == 4'd2 || op == 4'd3);
    if (w != 0) begin
      s = s_in[w-1] ^ inv;
      d = d_in[w-1];
      r = r_in[w-1];
      zero = ((r_in << (32 - w)) == 32'h0);
    end else begin
      s = 0; d = 0; r = 0; zero = 0;
    end
    if (op == 4'd11 || op == 4'd12) begin
      f[2] = (p == 64'h0);
      f[3] = p[63];
      f[1] = (op == 4'd11) ? ($signed(h_in) != ($signed(r_in) >>> 31)) : (h_in != 0);
    end else if (w != 0) begin
      f[3] = r;
      f[2] = zero;
      if (!(op >= 4'd4 && op <= 4'd10)) begin
        f[1] = (s == d) && (r != s);
        if (op == 4'd13) f[5] = (s & d) | ((s | d) & ~r);
        else             f[0] = (s & d) | ((s | d) & ~r);
      end
    end
    if (inv) f[0] = ~f[0];
    if (old[4] || op == 4'd1) em[2] = 1'b0;
    return (old & ~(em | 8'h10)) | (f & em);
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic [1:0] sz);
    if (op == 4'd14) return "R13";
    if (op == 4'd11) return "R8";
    if (op == 4'd12) return "R9";
    if (op == 4'd13) return "R10";
    if (op >= 4'd4 && op <= 4'd10) return "R7";
    if (sz == 2'd3) return "R6";
    if (op == 4'd2 || op == 4'd3) return "R5";
    return "R3/R4";
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got vld/ccs %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [1:0] sz,
      input logic [31:0] s, d, r, h, input logic [7:0] m, old,
      input logic [7:0] exp, input string tag);
    @(negedge clk);
    eval_vld = 1'b1; op_code = op; size_code = sz;
    src_opnd = s; dst_opnd = d; result = r; mul_hi = h;
    wr_mask = m; ccs_in = old;
    @(negedge clk);
    eval_vld = 1'b0;
    check(tag, {out_vld, ccs_q}, {1'b1, exp});
  endtask

  task automatic rnd(input logic [3:0] op, input logic [1:0] sz);
    logic [31:0] s = $urandom, d = $urandom, r = $urandom, h = $urandom;
    logic [7:0]  m = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
    logic [7:0]  o = 8'($urandom);
    if ($urandom % 4 == 0) r = 32'h0;
    if ($urandom % 4 == 0) h = {32{r[31]}};
    if ($urandom % 5 == 0) h = 32'h0;
    if (op == 4'd0 && $urandom % 2 == 0) r = s + d;
    run(op, sz, s, d, r, h, m, o, model(op, sz, s, d, r, h, m, o), tag_of(op, sz));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", {out_vld, ccs_q}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_vld, ccs_q}, 9'h000);
    // R3: byte 0x40+0x40 -> N,V
    run(4'd0, 2'd0, 32'h40, 32'h40, 32'h80, 0, 8'hFF, 8'h00, 8'h0A, "R3");
    // R4: word wrap to zero -> Z,V,C
    run(4'd0, 2'd2, 32'h80000000, 32'h80000000, 32'h0, 0, 8'hFF, 8'h00, 8'h07, "R4");
    // R2: no strobe, value held and valid low
    @(negedge clk);
    check("R2", {out_vld, ccs_q}, {1'b0, 8'h07});
    // R5: cmp equal -> Z only
    run(4'd3, 2'd2, 32'h5, 32'h5, 32'h0, 0, 8'hFF, 8'h00, 8'h04, "R5");
    // R6: halfword zero test ignores upper bits; size 3 sub gives C
    run(4'd0, 2'd1, 32'h1, 32'hFFFF, 32'h00010000, 0, 8'hFF, 8'h00, 8'h05, "R6");
    run(4'd2, 2'd3, 32'h1, 32'h1, 32'h0, 0, 8'hFF, 8'h00, 8'h01, "R6");
    // R7: move halfword negative, V/C cleared
    run(4'd4, 2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h8000, 0, 8'h0F, 8'h03, 8'h08, "R7");
    // R8: signed multiply
    run(4'd11, 2'd2, 0, 0, 32'h80000000, 32'hFFFFFFFF, 8'hFF, 8'h00, 8'h08, "R8");
    run(4'd11, 2'd2, 0, 0, 32'h80000000, 32'h0, 8'hFF, 8'h00, 8'h02, "R8");
    // R9: unsigned multiply
    run(4'd12, 2'd2, 0, 0, 32'h0, 32'h1, 8'hFF, 8'h00, 8'h02, "R9");
    run(4'd12, 2'd2, 0, 0, 32'h0, 32'h80000000, 8'hFF, 8'h00, 8'h0A, "R9");
    // R10: carry into R
    run(4'd13, 2'd0, 32'h80000000, 32'h80000000, 32'h0, 0, 8'hFF, 8'h00, 8'h26, "R10");
    // R11: add-with-carry keeps old Z; X set keeps old Z clear
    run(4'd1, 2'd2, 32'h1, 32'h1, 32'h2, 0, 8'hFF, 8'h04, 8'h04, "R11");
    run(4'd0, 2'd2, 32'h0, 32'h0, 32'h0, 0, 8'hFF, 8'h10, 8'h00, "R11");
    // R12: partial masks
    run(4'd0, 2'd2, 32'h80000000, 32'h80000000, 32'h0, 0, 8'h01, 8'hC0, 8'hC1, "R12");
    run(4'd0, 2'd2, 32'h1, 32'h1, 32'h2, 0, 8'h80, 8'h90, 8'h00, "R12");
    // R13: flags-live passes through
    run(4'd14, 2'd2, 32'h1, 32'h1, 32'h0, 0, 8'hFF, 8'h5A, 8'h5A, "R13");
    for (int i = 0; i < 3000; i++) rnd(4'($urandom), 2'($urandom));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule